// File: doc/BRIEF.md
# Four-Way Write-Back Data Cache Controller

This block is a set-associative data cache that sits between a single processor and a line-oriented memory. The processor issues one word-sized read or write at a time over a valid/ready request port. Each request is answered with a one-cycle response pulse. A read response carries the requested word. A write response acknowledges the write. On the memory side the block moves whole lines: a write request that carries a full victim line, and a read request whose line returns later on a separate valid strobe.

Each set has four ways, and each way holds a tag, a valid bit and a dirty bit. Writes are write-back and write-allocate. A miss takes the lowest-numbered invalid way of the set. When every way is valid, the victim is taken from a free-running pseudo-random generator. A dirty victim is written back in full before the new line is requested. Only one miss is in progress at a time.

The controller is a five-state machine:
- IDLE accepts a request and moves to LOOKUP.
- LOOKUP compares tags. On a hit it responds and returns to IDLE. On a miss it latches a victim way, then goes to WB_REQ if that victim is dirty, and to FILL_REQ if it is not.
- WB_REQ holds the writeback request until memory takes it, then moves to FILL_REQ.
- FILL_REQ holds the read request until memory takes it, then moves to FILL_WAIT.
- FILL_WAIT installs the returned line, then goes back to LOOKUP. The replayed lookup now hits.

Top module: `cache_wb_ctrl`

## Requirements
- R1: After reset every line is invalid, `cpu_req_ready` is high, and both `cpu_resp_valid` and `mem_req_valid` are low. The first access to any address therefore misses.
- R2: A byte address is split as follows:
  - offset: bits [4:0];
  - word select within the line: bits [4:2];
  - set index: the log2(SETS) bits directly above the offset;
  - tag: all remaining upper bits.

  Every memory request address is line aligned, with its low five bits zero.
- R3: A read hit raises `cpu_resp_valid`, carrying the addressed word, in the cycle after the request is accepted. A hit makes no memory request.
- R4: A write hit changes only the byte lanes whose `cpu_req_be` bit is set: bit i covers data bits 8i+7..8i. The other bytes keep their values, and the line becomes dirty.
- R5: A read miss issues exactly one memory read for the line-aligned address. Word k of a line travels on bits 32k+31..32k of the line bus. Once the line arrives, the response carries the requested word.
- R6: A write miss allocates. The line is first fetched from memory, and the enabled bytes are then merged into it. Later reads return the merged word, and the other words of that line hold the memory contents.
- R7: While a set still has an invalid way, a miss fills that way and evicts nothing. Four distinct tags in one set are therefore all kept.
- R8: When all four ways are valid, the victim is one of them, chosen pseudo-randomly. A clean victim is dropped without any memory write.
- R9: A dirty victim is written back before the refill request. The whole line goes to the victim's own line address and includes every earlier write to it.
- R10: From acceptance until its response, a request keeps `cpu_req_ready` low. A memory request holds its valid, address and direction stable until `mem_req_ready`.
- R11: `cpu_resp_valid` is a single-cycle pulse, issued once per accepted request.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cpu_req_valid | input | 1 | Processor request present |
| cpu_req_ready | output | 1 | Controller can accept a request |
| cpu_req_write | input | 1 | 1 = write, 0 = read |
| cpu_req_addr | input | ADDR_W | Byte address |
| cpu_req_wdata | input | WORD_W | Write data |
| cpu_req_be | input | WORD_W/8 | Byte lane enables for writes |
| cpu_resp_valid | output | 1 | Response pulse |
| cpu_resp_rdata | output | WORD_W | Read data |
| mem_req_valid | output | 1 | Memory request present |
| mem_req_ready | input | 1 | Memory takes the request |
| mem_req_write | output | 1 | 1 = line writeback, 0 = line fetch |
| mem_req_addr | output | ADDR_W | Line-aligned address |
| mem_req_wdata | output | LINE_BYTES*8 | Writeback line |
| mem_rvalid | input | 1 | Fetched line present |
| mem_rdata | input | LINE_BYTES*8 | Fetched line |

## Verification
The bench uses the default geometry: 32-bit addresses, 32-byte lines, four ways and eight sets. With eight sets the index is bits [7:5], so addresses 256 bytes apart collide in one set. Five such addresses are enough to fill a set and force evictions. The memory model toggles its ready every cycle and returns lines two cycles after a fetch is taken. This exercises held requests and the writeback-then-fill ordering. Because the victim is random, the eviction checks accept any way of the set but confirm that the line written back matches that way's own address and contents.

// File: rtl/cache_pkg.sv
package cache_pkg;

    // Controller states; the order here is not decoded anywhere.
    typedef enum logic [2:0] {
        ST_IDLE,
        ST_LOOKUP,
        ST_WB_REQ,
        ST_FILL_REQ,
        ST_FILL_WAIT
    } cache_state_t;

    localparam int unsigned BYTE_W = 8;

endpackage

// File: rtl/cache_tag_store.sv
module cache_tag_store #(
    parameter int unsigned WAYS  = 4,
    parameter int unsigned SETS  = 8,
    parameter int unsigned TAG_W = 24,
    localparam int unsigned IDX_W = (SETS > 1) ? $clog2(SETS) : 1,
    localparam int unsigned WAY_W = (WAYS > 1) ? $clog2(WAYS) : 1
) (
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic [IDX_W-1:0]            idx,
    output logic [WAYS-1:0][TAG_W-1:0]  way_tag,
    output logic [WAYS-1:0]             way_valid,
    output logic [WAYS-1:0]             way_dirty,
    input  logic                        fill_we,
    input  logic [WAY_W-1:0]            fill_way,
    input  logic [TAG_W-1:0]            fill_tag,
    input  logic                        mark_dirty,
    input  logic [WAY_W-1:0]            dirty_way
);

    logic [TAG_W-1:0] tags  [SETS][WAYS];
    logic [WAYS-1:0]  valid [SETS];
    logic [WAYS-1:0]  dirty [SETS];

    always_ff @(posedge clk) begin
        if (fill_we) begin
            tags[idx][fill_way] <= fill_tag;
        end
    end

    // R1: state bits clear on reset; a fill sets valid and clears dirty
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int s = 0; s < SETS; s++) begin
                valid[s] <= '0;
                dirty[s] <= '0;
            end
        end else if (fill_we) begin
            valid[idx][fill_way] <= 1'b1;
            dirty[idx][fill_way] <= 1'b0;
        end else if (mark_dirty) begin
            dirty[idx][dirty_way] <= 1'b1;
        end
    end

    for (genvar w = 0; w < WAYS; w++) begin : g_rd
        assign way_tag[w] = tags[idx][w];
    end
    assign way_valid = valid[idx];
    assign way_dirty = dirty[idx];

endmodule

// File: rtl/cache_line_store.sv
module cache_line_store #(
    parameter int unsigned WAYS   = 4,
    parameter int unsigned SETS   = 8,
    parameter int unsigned LINE_W = 256,
    parameter int unsigned WORD_W = 32,
    localparam int unsigned IDX_W  = (SETS > 1) ? $clog2(SETS) : 1,
    localparam int unsigned WAY_W  = (WAYS > 1) ? $clog2(WAYS) : 1,
    localparam int unsigned WORDS  = LINE_W / WORD_W,
    localparam int unsigned WSEL_W = (WORDS > 1) ? $clog2(WORDS) : 1,
    localparam int unsigned LANES  = WORD_W / cache_pkg::BYTE_W
) (
    input  logic                        clk,
    input  logic [IDX_W-1:0]            idx,
    output logic [WAYS-1:0][LINE_W-1:0] way_line,
    input  logic                        fill_we,
    input  logic [WAY_W-1:0]            fill_way,
    input  logic [LINE_W-1:0]           fill_line,
    input  logic                        word_we,
    input  logic [WAY_W-1:0]            word_way,
    input  logic [WSEL_W-1:0]           word_sel,
    input  logic [WORD_W-1:0]           word_data,
    input  logic [LANES-1:0]            word_be
);

    localparam int unsigned BW = cache_pkg::BYTE_W;

    logic [LINE_W-1:0] lines [SETS][WAYS];

    // R4: byte-lane merge, R5/R6: whole-line install on fill
    always_ff @(posedge clk) begin
        if (fill_we) begin
            lines[idx][fill_way] <= fill_line;
        end else if (word_we) begin
            for (int b = 0; b < LANES; b++) begin
                if (word_be[b]) begin
                    lines[idx][word_way][int'(word_sel)*WORD_W + b*BW +: BW]
                        <= word_data[b*BW +: BW];
                end
            end
        end
    end

    for (genvar w = 0; w < WAYS; w++) begin : g_rd
        assign way_line[w] = lines[idx][w];
    end

endmodule

// File: rtl/cache_victim_pick.sv
module cache_victim_pick #(
    parameter int unsigned WAYS = 4,
    localparam int unsigned WAY_W = (WAYS > 1) ? $clog2(WAYS) : 1,
    localparam int unsigned LFSR_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WAYS-1:0]  way_valid,
    output logic [WAY_W-1:0] victim
);

    logic [LFSR_W-1:0] lfsr;
    logic              feedback;

    assign feedback = lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10];

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            lfsr <= 16'hACE1;
        end else begin
            lfsr <= {lfsr[LFSR_W-2:0], feedback};
        end
    end

    // R7: lowest invalid way wins; R8: otherwise pseudo-random
    always_comb begin
        victim = lfsr[WAY_W-1:0];
        for (int w = WAYS - 1; w >= 0; w--) begin
            if (!way_valid[w]) begin
                victim = WAY_W'(w);
            end
        end
    end

endmodule

// File: rtl/cache_wb_ctrl.sv
module cache_wb_ctrl
    import cache_pkg::*;
#(
    parameter int unsigned ADDR_W     = 32,
    parameter int unsigned LINE_BYTES = 32,
    parameter int unsigned WAYS       = 4,
    parameter int unsigned SETS       = 8,
    parameter int unsigned WORD_W     = 32,
    localparam int unsigned LINE_W = LINE_BYTES * 8,
    localparam int unsigned LANES  = WORD_W / 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cpu_req_valid,
    output logic              cpu_req_ready,
    input  logic              cpu_req_write,
    input  logic [ADDR_W-1:0] cpu_req_addr,
    input  logic [WORD_W-1:0] cpu_req_wdata,
    input  logic [LANES-1:0]  cpu_req_be,
    output logic              cpu_resp_valid,
    output logic [WORD_W-1:0] cpu_resp_rdata,
    output logic              mem_req_valid,
    input  logic              mem_req_ready,
    output logic              mem_req_write,
    output logic [ADDR_W-1:0] mem_req_addr,
    output logic [LINE_W-1:0] mem_req_wdata,
    input  logic              mem_rvalid,
    input  logic [LINE_W-1:0] mem_rdata
);

    localparam int unsigned OFF_W  = $clog2(LINE_BYTES);
    localparam int unsigned IDX_W  = (SETS > 1) ? $clog2(SETS) : 1;
    localparam int unsigned TAG_W  = ADDR_W - IDX_W - OFF_W;
    localparam int unsigned WAY_W  = (WAYS > 1) ? $clog2(WAYS) : 1;
    localparam int unsigned WORDS  = LINE_W / WORD_W;
    localparam int unsigned WSEL_W = (WORDS > 1) ? $clog2(WORDS) : 1;

    cache_state_t state_q, state_d;

    logic              req_write_q;
    logic [ADDR_W-1:0] req_addr_q;
    logic [WORD_W-1:0] req_wdata_q;
    logic [LANES-1:0]  req_be_q;
    logic [WAY_W-1:0]  victim_q;

    // R2: address split
    logic [IDX_W-1:0]  idx_q;
    logic [TAG_W-1:0]  tag_q;
    logic [WSEL_W-1:0] wsel_q;

    assign idx_q  = req_addr_q[OFF_W +: IDX_W];
    assign tag_q  = req_addr_q[ADDR_W-1 -: TAG_W];
    assign wsel_q = req_addr_q[OFF_W-1 -: WSEL_W];

    logic [WAYS-1:0][TAG_W-1:0]  way_tag;
    logic [WAYS-1:0]             way_valid;
    logic [WAYS-1:0]             way_dirty;
    logic [WAYS-1:0][LINE_W-1:0] way_line;
    logic [WAY_W-1:0]            pick_way;

    logic                        tag_fill_we;
    logic                        mark_dirty;
    logic                        word_we;

    // Per-way tag compare
    logic [WAYS-1:0] hit_vec;
    for (genvar w = 0; w < WAYS; w++) begin : g_cmp
        assign hit_vec[w] = way_valid[w] && (way_tag[w] == tag_q);
    end

    logic             hit;
    logic [WAY_W-1:0] hit_way;

    always_comb begin
        hit_way = '0;
        for (int w = 0; w < WAYS; w++) begin
            if (hit_vec[w]) begin
                hit_way = WAY_W'(w);
            end
        end
    end
    assign hit = |hit_vec;

    cache_tag_store #(
        .WAYS  (WAYS),
        .SETS  (SETS),
        .TAG_W (TAG_W)
    ) u_tags (
        .clk        (clk),
        .rst_n      (rst_n),
        .idx        (idx_q),
        .way_tag    (way_tag),
        .way_valid  (way_valid),
        .way_dirty  (way_dirty),
        .fill_we    (tag_fill_we),
        .fill_way   (victim_q),
        .fill_tag   (tag_q),
        .mark_dirty (mark_dirty),
        .dirty_way  (hit_way)
    );

    cache_line_store #(
        .WAYS   (WAYS),
        .SETS   (SETS),
        .LINE_W (LINE_W),
        .WORD_W (WORD_W)
    ) u_lines (
        .clk       (clk),
        .idx       (idx_q),
        .way_line  (way_line),
        .fill_we   (tag_fill_we),
        .fill_way  (victim_q),
        .fill_line (mem_rdata),
        .word_we   (word_we),
        .word_way  (hit_way),
        .word_sel  (wsel_q),
        .word_data (req_wdata_q),
        .word_be   (req_be_q)
    );

    cache_victim_pick #(
        .WAYS (WAYS)
    ) u_victim (
        .clk       (clk),
        .rst_n     (rst_n),
        .way_valid (way_valid),
        .victim    (pick_way)
    );

    // State register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    // Next-state logic
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: begin
                if (cpu_req_valid) begin
                    state_d = ST_LOOKUP;
                end
            end
            ST_LOOKUP: begin
                if (hit) begin
                    state_d = ST_IDLE;
                end else if (way_valid[pick_way] && way_dirty[pick_way]) begin
                    state_d = ST_WB_REQ;       // R9
                end else begin
                    state_d = ST_FILL_REQ;     // R5, R8
                end
            end
            ST_WB_REQ: begin
                if (mem_req_ready) begin
                    state_d = ST_FILL_REQ;
                end
            end
            ST_FILL_REQ: begin
                if (mem_req_ready) begin
                    state_d = ST_FILL_WAIT;
                end
            end
            ST_FILL_WAIT: begin
                if (mem_rvalid) begin
                    state_d = ST_LOOKUP;       // replay: R6 write-allocate
                end
            end
            default: state_d = ST_IDLE;
        endcase
    end

    // Request and victim capture
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            req_write_q <= 1'b0;
            req_addr_q  <= '0;
            req_wdata_q <= '0;
            req_be_q    <= '0;
            victim_q    <= '0;
        end else begin
            if (state_q == ST_IDLE && cpu_req_valid) begin
                req_write_q <= cpu_req_write;
                req_addr_q  <= cpu_req_addr;
                req_wdata_q <= cpu_req_wdata;
                req_be_q    <= cpu_req_be;
            end
            if (state_q == ST_LOOKUP && !hit) begin
                victim_q <= pick_way;
            end
        end
    end

    // Outputs
    always_comb begin
        cpu_req_ready  = 1'b0;
        cpu_resp_valid = 1'b0;
        cpu_resp_rdata = way_line[hit_way][int'(wsel_q)*WORD_W +: WORD_W];
        mem_req_valid  = 1'b0;
        mem_req_write  = 1'b0;
        mem_req_addr   = {tag_q, idx_q, {OFF_W{1'b0}}};
        mem_req_wdata  = way_line[victim_q];
        tag_fill_we    = 1'b0;
        mark_dirty     = 1'b0;
        word_we        = 1'b0;
        unique case (state_q)
            ST_IDLE: begin
                cpu_req_ready = 1'b1;
            end
            ST_LOOKUP: begin
                if (hit) begin
                    cpu_resp_valid = 1'b1;       // R3, R11
                    word_we        = req_write_q; // R4
                    mark_dirty     = req_write_q;
                end
            end
            ST_WB_REQ: begin
                mem_req_valid = 1'b1;
                mem_req_write = 1'b1;
                mem_req_addr  = {way_tag[victim_q], idx_q, {OFF_W{1'b0}}};
            end
            ST_FILL_REQ: begin
                mem_req_valid = 1'b1;
            end
            ST_FILL_WAIT: begin
                tag_fill_we = mem_rvalid;
            end
            default: begin
                cpu_req_ready = 1'b0;
            end
        endcase
    end

endmodule

// File: rtl/cache_wb_checker.sv
module cache_wb_checker #(
    parameter int unsigned ADDR_W     = 32,
    parameter int unsigned LINE_BYTES = 32,
    localparam int unsigned OFF_W = $clog2(LINE_BYTES)
) (
    input logic              clk,
    input logic              rst_n,
    input logic              cpu_req_valid,
    input logic              cpu_req_ready,
    input logic              cpu_resp_valid,
    input logic              mem_req_valid,
    input logic              mem_req_ready,
    input logic              mem_req_write,
    input logic [ADDR_W-1:0] mem_req_addr
);

    a_r10_busy_no_accept: assert property (@(posedge clk) disable iff (!rst_n)
        mem_req_valid |-> !cpu_req_ready);

    a_r10_accept_then_busy: assert property (@(posedge clk) disable iff (!rst_n)
        (cpu_req_valid && cpu_req_ready) |=> !cpu_req_ready);

    a_r10_mem_req_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req_valid && !mem_req_ready) |=>
            (mem_req_valid && $stable(mem_req_addr) && $stable(mem_req_write)));

    a_r11_resp_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        cpu_resp_valid |=> !cpu_resp_valid);

    a_r2_line_aligned: assert property (@(posedge clk) disable iff (!rst_n)
        mem_req_valid |-> (mem_req_addr[OFF_W-1:0] == '0));

    a_r9_wb_then_fill: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req_valid && mem_req_write && mem_req_ready) |=>
            (mem_req_valid && !mem_req_write));

endmodule

bind cache_wb_ctrl cache_wb_checker #(
    .ADDR_W     (ADDR_W),
    .LINE_BYTES (LINE_BYTES)
) u_wb_checker (
    .clk            (clk),
    .rst_n          (rst_n),
    .cpu_req_valid  (cpu_req_valid),
    .cpu_req_ready  (cpu_req_ready),
    .cpu_resp_valid (cpu_resp_valid),
    .mem_req_valid  (mem_req_valid),
    .mem_req_ready  (mem_req_ready),
    .mem_req_write  (mem_req_write),
    .mem_req_addr   (mem_req_addr)
);

// File: tb/test_cache_wb_ctrl.sv
module test_cache_wb_ctrl;

    localparam int CLK_PERIOD = 10;
    localparam logic [31:0] PAT = 32'hA5A5_0000;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         cpu_req_valid = 1'b0;
    logic         cpu_req_ready;
    logic         cpu_req_write = 1'b0;
    logic [31:0]  cpu_req_addr = '0;
    logic [31:0]  cpu_req_wdata = '0;
    logic [3:0]   cpu_req_be = '0;
    logic         cpu_resp_valid;
    logic [31:0]  cpu_resp_rdata;
    logic         mem_req_valid;
    logic         mem_req_ready = 1'b0;
    logic         mem_req_write;
    logic [31:0]  mem_req_addr;
    logic [255:0] mem_req_wdata;
    logic         mem_rvalid = 1'b0;
    logic [255:0] mem_rdata = '0;

    always #(CLK_PERIOD/2) clk = ~clk;

    cache_wb_ctrl i_cache_wb_ctrl (
        .clk            (clk),
        .rst_n          (rst_n),
        .cpu_req_valid  (cpu_req_valid),
        .cpu_req_ready  (cpu_req_ready),
        .cpu_req_write  (cpu_req_write),
        .cpu_req_addr   (cpu_req_addr),
        .cpu_req_wdata  (cpu_req_wdata),
        .cpu_req_be     (cpu_req_be),
        .cpu_resp_valid (cpu_resp_valid),
        .cpu_resp_rdata (cpu_resp_rdata),
        .mem_req_valid  (mem_req_valid),
        .mem_req_ready  (mem_req_ready),
        .mem_req_write  (mem_req_write),
        .mem_req_addr   (mem_req_addr),
        .mem_req_wdata  (mem_req_wdata),
        .mem_rvalid     (mem_rvalid),
        .mem_rdata      (mem_rdata)
    );

    int errors = 0;
    int checks = 0;

    // ---------------- memory model ----------------
    logic [255:0] mem_store [logic [31:0]];
    logic [31:0]  gold [logic [31:0]];
    int           wb_count = 0, fill_count = 0;
    logic [31:0]  last_wb_addr = '0, last_fill_addr = '0;
    logic [255:0] last_wb_data = '0;
    longint       cyc = 0, wb_cyc = 0, fill_cyc = 0;
    int           rd_cnt = 0;
    logic [31:0]  rd_addr = '0;

    function automatic logic [255:0] pat_line(input logic [31:0] la);
        logic [255:0] l;
        for (int k = 0; k < 8; k++) l[k*32 +: 32] = (la + 32'(4*k)) ^ PAT;
        return l;
    endfunction

    function automatic logic [31:0] gold_rd(input logic [31:0] a);
        logic [31:0] wa = {a[31:2], 2'b00};
        if (gold.exists(wa)) return gold[wa];
        return wa ^ PAT;
    endfunction

    function automatic logic [255:0] gold_line(input logic [31:0] la);
        logic [255:0] l;
        for (int k = 0; k < 8; k++) l[k*32 +: 32] = gold_rd(la + 32'(4*k));
        return l;
    endfunction

    always @(posedge clk) begin
        cyc <= cyc + 1;
        mem_req_ready <= rst_n ? ~mem_req_ready : 1'b0;
        mem_rvalid <= (rd_cnt == 1);
        if (rd_cnt == 1) begin
            mem_rdata <= mem_store.exists(rd_addr) ? mem_store[rd_addr] : pat_line(rd_addr);
        end
        if (rd_cnt != 0) rd_cnt <= rd_cnt - 1;
        if (rst_n && mem_req_valid && mem_req_ready) begin
            if (mem_req_write) begin
                mem_store[mem_req_addr] = mem_req_wdata;
                wb_count <= wb_count + 1;
                last_wb_addr <= mem_req_addr;
                last_wb_data <= mem_req_wdata;
                wb_cyc <= cyc;
            end else begin
                rd_addr <= mem_req_addr;
                rd_cnt <= 2;
                fill_count <= fill_count + 1;
                last_fill_addr <= mem_req_addr;
                fill_cyc <= cyc;
            end
        end
    end

    // ---------------- helpers ----------------
    task automatic chk(input bit ok, input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s: actual=%h expected=%h", req, what, act, exp);
        end
    endtask

    int busy_viol = 0;

    task automatic access(input logic wr, input logic [31:0] a, input logic [31:0] d,
                          input logic [3:0] be, output logic [31:0] rd, output int lat);
        @(negedge clk);
        while (!cpu_req_ready) @(negedge clk);
        cpu_req_valid = 1'b1;
        cpu_req_write = wr;
        cpu_req_addr  = a;
        cpu_req_wdata = d;
        cpu_req_be    = be;
        @(posedge clk);
        @(negedge clk);
        cpu_req_valid = 1'b0;
        lat = 0;
        while (!cpu_resp_valid) begin
            if (cpu_req_ready) busy_viol++;
            @(negedge clk);
            lat++;
        end
        if (cpu_req_ready) busy_viol++;
        rd = cpu_resp_rdata;
        @(negedge clk);
        chk(!cpu_resp_valid, "R11", "response longer than one cycle",
            32'(cpu_resp_valid), 32'd0);
    endtask

    task automatic cpu_write(input logic [31:0] a, input logic [31:0] d, input logic [3:0] be);
        logic [31:0] rd, cur, nw;
        int lat;
        access(1'b1, a, d, be, rd, lat);
        cur = gold_rd(a);
        for (int b = 0; b < 4; b++) nw[b*8 +: 8] = be[b] ? d[b*8 +: 8] : cur[b*8 +: 8];
        gold[{a[31:2], 2'b00}] = nw;
    endtask

    task automatic cpu_read(input logic [31:0] a, input string req, output int lat);
        logic [31:0] rd;
        access(1'b0, a, '0, '0, rd, lat);
        chk(rd === gold_rd(a), req, "read data", rd, gold_rd(a));
    endtask

    // ---------------- scenarios ----------------
    task automatic t_reset();
        int f0, lat;
        chk(cpu_req_ready === 1'b1, "R1", "ready after reset", 32'(cpu_req_ready), 32'd1);
        chk(cpu_resp_valid === 1'b0, "R1", "resp after reset", 32'(cpu_resp_valid), 32'd0);
        chk(mem_req_valid === 1'b0, "R1", "mem req after reset", 32'(mem_req_valid), 32'd0);
        f0 = fill_count;
        cpu_read(32'h0000_7000, "R1", lat);
        chk(fill_count == f0 + 1, "R1", "first access misses", 32'(fill_count - f0), 32'd1);
    endtask

    task automatic t_read_miss_hit();
        int f0, w0, lat;
        f0 = fill_count;
        cpu_read(32'h0000_1234, "R5", lat);
        chk(fill_count == f0 + 1, "R5", "single fill", 32'(fill_count - f0), 32'd1);
        chk(last_fill_addr == 32'h0000_1220, "R2", "line aligned fill address",
            last_fill_addr, 32'h0000_1220);
        f0 = fill_count; w0 = wb_count;
        cpu_read(32'h0000_123C, "R3", lat);
        chk(lat == 0, "R3", "hit latency", 32'(lat), 32'd0);
        chk(fill_count == f0 && wb_count == w0, "R3", "no memory traffic on hit",
            32'(fill_count - f0), 32'd0);
    endtask

    task automatic t_write_hit();
        int f0, w0, lat;
        f0 = fill_count; w0 = wb_count;
        cpu_write(32'h0000_1238, 32'hDEAD_BEEF, 4'b0101);
        cpu_read(32'h0000_1238, "R4", lat);
        chk(gold_rd(32'h0000_1238) == ((32'h0000_1238 ^ PAT) & 32'hFF00_FF00 | 32'h00AD_00EF),
            "R4", "model merge", gold_rd(32'h0000_1238), 32'h0000_1238);
        chk(fill_count == f0 && wb_count == w0, "R4", "no traffic on write hit",
            32'(wb_count - w0), 32'd0);
    endtask

    task automatic t_write_miss();
        int f0, w0, lat;
        f0 = fill_count; w0 = wb_count;
        cpu_write(32'h0000_5544, 32'h1357_9BDF, 4'b1111);
        chk(fill_count == f0 + 1, "R6", "write miss fetches line", 32'(fill_count - f0), 32'd1);
        chk(wb_count == w0, "R6", "no memory write for write miss", 32'(wb_count - w0), 32'd0);
        cpu_read(32'h0000_5544, "R6", lat);
        cpu_read(32'h0000_5540, "R6", lat);
    endtask

    task automatic t_fill_ways();
        int f0, lat;
        f0 = fill_count;
        for (int k = 0; k < 4; k++) cpu_read(32'h0000_0060 + 32'(k*256), "R7", lat);
        chk(fill_count == f0 + 4, "R7", "four fills", 32'(fill_count - f0), 32'd4);
        f0 = fill_count;
        for (int k = 0; k < 4; k++) begin
            cpu_read(32'h0000_0064 + 32'(k*256), "R7", lat);
            chk(lat == 0, "R7", "way retained", 32'(lat), 32'd0);
        end
        chk(fill_count == f0, "R7", "no refill", 32'(fill_count - f0), 32'd0);
    endtask

    task automatic t_clean_evict();
        int f0, w0, lat;
        f0 = fill_count; w0 = wb_count;
        cpu_read(32'h0000_0460, "R8", lat);
        chk(fill_count == f0 + 1, "R8", "fill on full set", 32'(fill_count - f0), 32'd1);
        chk(wb_count == w0, "R8", "clean victim not written", 32'(wb_count - w0), 32'd0);
        for (int k = 0; k < 5; k++) cpu_read(32'h0000_0068 + 32'(k*256), "R8", lat);
        chk(wb_count == w0, "R8", "still no writeback", 32'(wb_count - w0), 32'd0);
    endtask

    task automatic t_dirty_evict();
        int w0, lat;
        logic [31:0] va;
        for (int k = 0; k < 4; k++)
            cpu_write(32'h0000_00A4 + 32'(k*256), 32'h1111_0000 + 32'(k), 4'b1111);
        w0 = wb_count;
        busy_viol = 0;
        cpu_read(32'h0000_04A0, "R9", lat);
        chk(busy_viol == 0, "R10", "ready low while busy", 32'(busy_viol), 32'd0);
        chk(wb_count == w0 + 1, "R9", "dirty victim written back", 32'(wb_count - w0), 32'd1);
        va = last_wb_addr;
        chk(va[7:0] == 8'hA0 && va[31:8] < 24'd4, "R9", "victim address in set", va, 32'h0000_00A0);
        chk(last_wb_data == gold_line(va), "R9", "writeback line contents",
            last_wb_data[63:32], gold_line(va) >> 32);
        chk(wb_cyc < fill_cyc, "R9", "writeback precedes refill", 32'(wb_cyc), 32'(fill_cyc));
        cpu_read(va + 32'd4, "R9", lat);
    endtask

    // ---------------- main ----------------
    bit done = 1'b0;

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_read_miss_hit();
        t_write_hit();
        t_write_miss();
        t_fill_ways();
        t_clean_evict();
        t_dirty_evict();
        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        #(CLK_PERIOD * 50000);
        if (!done) begin
            errors++;
            checks++;
            $display("FAIL watchdog: actual=hung expected=finished");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

endmodule